// File: doc/BRIEF.md
# Double-Base Term-Product Multiplier

This block multiplies two operands that arrive already expressed in double-base form. Each operand is a sum of up to five terms of the form 2^e2 · 3^e3, where each exponent is a small unsigned field and each term has its own valid bit. The block never builds an array multiplier. For every pairing of a term of the first operand with a term of the second, it adds the two base-two exponents and the two base-three exponents. An eight-entry table then supplies the power of three, and a left shift by the base-two sum completes that partial product.

All 25 partial products are formed side by side and registered. A five-level registered tree of 24 two-input adders then sums them into a 16-bit binary product. A new operand pair can be accepted on every clock. Each result leaves the block a fixed six cycles after its inputs, with a valid strobe. Conversion from binary into double-base form is done by the neighbouring logic and is not part of this block.

Top module: `dbl_base_mul`

## Requirements
- R1: Term t of an operand (t = 0..4) takes its base-two exponent from bits [2t+1:2t] of the exp2 bus, its base-three exponent from bits [2t+1:2t] of the exp3 bus, and its enable from bit t of the term-valid bus. The operand value is the sum of 2^e2 · 3^e3 over its enabled terms.
- R2: For an accepted input pair, the product output equals (value of A × value of B) mod 2^16.
- R3: A term pairing contributes only when both of its terms are enabled. If either operand has no enabled term, the product is 0, whatever the exponent fields hold.
- R4: Exponent sums up to 6 on each base are exact. A single pairing of (3,3) with (3,3) yields 2^6 · 3^6 = 46656, which is nonzero.
- R5: A pair presented with inValid high at a rising edge produces outValid high and its product after exactly six rising edges, counting the capturing edge as the first. outValid is low in every cycle that has no matching input.
- R6: Inputs on consecutive cycles, or with gaps between them, each produce their own result, in input order, one per cycle.
- R7: While outValid is low the product output holds its last value. Exponent and valid fields presented with inValid low have no effect on any output.
- R8: While rstN is low and right after it rises, outValid is 0 and product is 0.
- R9: Sums beyond 16 bits wrap modulo 2^16. With all ten terms set to (3,3), the product is 1080^2 mod 65536 = 52288.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair present this cycle |
| aExp2 | input | 10 | Operand A base-two exponents, 2 bits per term |
| aExp3 | input | 10 | Operand A base-three exponents, 2 bits per term |
| aTermValid | input | 5 | Operand A per-term enables |
| bExp2 | input | 10 | Operand B base-two exponents, 2 bits per term |
| bExp3 | input | 10 | Operand B base-three exponents, 2 bits per term |
| bTermValid | input | 5 | Operand B per-term enables |
| outValid | output | 1 | Product valid |
| product | output | 16 | Binary product, modulo 2^16 |

## Verification
A faulty table entry, shift amount or gating term would show up as a wrong product six cycles after any input pair that uses that pairing. The sweep over greedy decompositions of all 8-bit multiplicands reaches every slot, every exponent and many mixes of them. A faulty valid chain or a stage that fails to load would show up within one result as a product that is misplaced, stale or duplicated. It would also show up as outValid in the wrong cycle. Idle cycles loaded with garbage fields check that the held output does not move.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  parameter int NTERM = 5;
  parameter int EXPW  = 2;
  parameter int OUTW  = 16;

  localparam int SUMW   = EXPW + 1;
  localparam int LUTN   = 1 << SUMW;
  localparam int POWW   = $clog2(3 ** (LUTN - 1));
  localparam int NPROD  = NTERM * NTERM;
  localparam int LEVELS = $clog2(NPROD);
  localparam int LAT    = LEVELS + 1;

  typedef logic [POWW-1:0] powTab_t [LUTN];

  typedef struct packed {
    logic              capture;
    logic [LEVELS-1:0] advance;
  } strobe_t;

  function automatic int nodesAt(int lvl);
    return (NPROD + (1 << lvl) - 1) >> lvl;
  endfunction

  function automatic powTab_t buildPow3();
    powTab_t tab;
    int run;
    run = 1;
    for (int n = 0; n < LUTN; n++) begin
      tab[n] = POWW'(run);
      run = run * 3;
    end
    return tab;
  endfunction
endpackage

// File: rtl/dbm_ctrl.sv
module dbm_ctrl
  import dbm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t stb,
  output logic    outValid
);
  logic [LEVELS:0] vPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[LEVELS-1:0], inValid};
  end

  always_comb begin
    stb.capture = inValid;
    stb.advance = vPipe[LEVELS-1:0];
  end

  assign outValid = vPipe[LEVELS];
endmodule

// File: rtl/dbm_datapath.sv
module dbm_datapath
  import dbm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [NTERM*EXPW-1:0] aExp2,
  input  logic [NTERM*EXPW-1:0] aExp3,
  input  logic [NTERM-1:0]      aTermValid,
  input  logic [NTERM*EXPW-1:0] bExp2,
  input  logic [NTERM*EXPW-1:0] bExp3,
  input  logic [NTERM-1:0]      bTermValid,
  output logic [OUTW-1:0]       product
);
  localparam powTab_t POW3 = buildPow3();

  for (genvar l = 0; l <= LEVELS; l++) begin : lv
    for (genvar k = 0; k < nodesAt(l); k++) begin : nd
      logic [OUTW-1:0] q;
      if (l == 0) begin : g_term
        localparam int IA = k / NTERM;
        localparam int IB = k % NTERM;
        logic [SUMW-1:0] sum2, sum3;
        logic [OUTW-1:0] term;
        always_comb begin
          sum2 = SUMW'(aExp2[IA*EXPW +: EXPW]) + SUMW'(bExp2[IB*EXPW +: EXPW]);
          sum3 = SUMW'(aExp3[IA*EXPW +: EXPW]) + SUMW'(bExp3[IB*EXPW +: EXPW]);
          term = (aTermValid[IA] && bTermValid[IB])
               ? (OUTW'(POW3[sum3]) << sum2) : '0;
        end
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)            q <= '0;
          else if (stb.capture) q <= term;
        end
      end else if (2*k + 1 < nodesAt(l-1)) begin : g_add
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                 q <= '0;
          else if (stb.advance[l-1]) q <= lv[l-1].nd[2*k].q + lv[l-1].nd[2*k+1].q;
        end
      end else begin : g_pass
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                 q <= '0;
          else if (stb.advance[l-1]) q <= lv[l-1].nd[2*k].q;
        end
      end
    end
  end

  assign product = lv[LEVELS].nd[0].q;
endmodule

// File: rtl/dbl_base_mul.sv
module dbl_base_mul
  import dbm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [NTERM*EXPW-1:0] aExp2,
  input  logic [NTERM*EXPW-1:0] aExp3,
  input  logic [NTERM-1:0]      aTermValid,
  input  logic [NTERM*EXPW-1:0] bExp2,
  input  logic [NTERM*EXPW-1:0] bExp3,
  input  logic [NTERM-1:0]      bTermValid,
  output logic                  outValid,
  output logic [OUTW-1:0]       product
);
  strobe_t stb;

  dbm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stb(stb), .outValid(outValid)
  );

  dbm_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .aExp2(aExp2), .aExp3(aExp3), .aTermValid(aTermValid),
    .bExp2(bExp2), .bExp3(bExp3), .bTermValid(bTermValid),
    .product(product)
  );
endmodule

// File: rtl/dbm_chk.sv
module dbm_chk
  import dbm_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [NTERM-1:0]   aTermValid,
  input logic [NTERM-1:0]   bTermValid,
  input logic               outValid,
  input logic [OUTW-1:0]    product
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceRst <= '0;
    else if (sinceRst < CW'(LAT)) sinceRst <= sinceRst + 1'b1;
  end

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= CW'(LAT)) |-> (outValid == $past(inValid, LAT)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(product));

  // R3
  no_pair_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst >= CW'(LAT)) && $past(inValid && !(|aTermValid && |bTermValid), LAT))
      |-> (product == '0));

  // R4
  single_pair_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst >= CW'(LAT)) &&
     $past(inValid && $countones(aTermValid) == 1 && $countones(bTermValid) == 1, LAT))
      |-> (product != '0));

  // R8
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && product == '0));
endmodule

bind dbl_base_mul dbm_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid),
  .aTermValid(aTermValid), .bTermValid(bTermValid),
  .outValid(outValid), .product(product)
);

// File: tb/tb_dbl_base_mul.sv
module tb_dbl_base_mul;
  import dbm_pkg::*;

  localparam int FW   = NTERM * EXPW;
  localparam int MAXC = 16384;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic inValid;
  logic [FW-1:0] aExp2, aExp3, bExp2, bExp3;
  logic [NTERM-1:0] aTermValid, bTermValid;
  logic outValid;
  logic [OUTW-1:0] product;

  dbl_base_mul dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .aExp2(aExp2), .aExp3(aExp3), .aTermValid(aTermValid),
    .bExp2(bExp2), .bExp3(bExp3), .bTermValid(bTermValid),
    .outValid(outValid), .product(product)
  );

  int nChk = 0, nBad = 0, t = 0, held = 0;
  bit done = 0;
  bit hV[MAXC];
  int hE[MAXC];
  string hT[MAXC];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int termVal(int e2, int e3);
    return (1 << e2) * (3 ** e3);
  endfunction

  // one cycle: check the output due now, then drive the next input
  task automatic step(bit v, logic [FW-1:0] a2, logic [FW-1:0] a3, logic [NTERM-1:0] av,
                      logic [FW-1:0] b2, logic [FW-1:0] b3, logic [NTERM-1:0] bv,
                      int exp, string tag);
    @(negedge clk);
    if (t >= LAT && hV[t-LAT]) begin
      chk({hT[t-LAT], " R5 outValid"}, 32'(outValid), 32'd1);
      chk(hT[t-LAT], 32'(product), 32'(hE[t-LAT]));
      held = hE[t-LAT];
    end else begin
      chk("R5 outValid idle", 32'(outValid), 32'd0);
      chk("R7 held product", 32'(product), 32'(held));
    end
    inValid = v; aExp2 = a2; aExp3 = a3; aTermValid = av;
    bExp2 = b2; bExp3 = b3; bTermValid = bv;
    hV[t] = v; hE[t] = exp & ((1 << OUTW) - 1); hT[t] = tag;
    t++;
  endtask

  // greedy decomposition placed into rotated slots, garbage in unused slots
  task automatic makeOp(int x, output logic [FW-1:0] e2, output logic [FW-1:0] e3,
                        output logic [NTERM-1:0] vv, output int rep);
    int r = x;
    int base = int'($urandom % NTERM);
    e2 = FW'($urandom); e3 = FW'($urandom); vv = '0; rep = 0;
    for (int n = 0; n < NTERM; n++) begin
      int best = 0, bi = 0, bj = 0;
      int s = (base + n) % NTERM;
      if (r > 0) begin
        for (int i = 0; i < (1 << EXPW); i++)
          for (int j = 0; j < (1 << EXPW); j++)
            if (termVal(i, j) <= r && termVal(i, j) > best) begin
              best = termVal(i, j); bi = i; bj = j;
            end
        e2[s*EXPW +: EXPW] = EXPW'(bi);
        e3[s*EXPW +: EXPW] = EXPW'(bj);
        vv[s] = 1'b1;
        rep += best; r -= best;
      end
    end
  endtask

  task automatic pairStep(int x, int y, string tag);
    logic [FW-1:0] a2, a3, b2, b3;
    logic [NTERM-1:0] av, bv;
    int ra, rb;
    makeOp(x, a2, a3, av, ra);
    makeOp(y, b2, b3, bv, rb);
    step(1'b1, a2, a3, av, b2, b3, bv, ra * rb, tag);
  endtask

  task automatic idleStep();
    step(1'b0, FW'($urandom), FW'($urandom), NTERM'($urandom),
         FW'($urandom), FW'($urandom), NTERM'($urandom), 0, "");
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0;
    aExp2 = '0; aExp3 = '0; aTermValid = '0;
    bExp2 = '0; bExp3 = '0; bTermValid = '0;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk("R8 reset outValid", 32'(outValid), 32'd0);
      chk("R8 reset product", 32'(product), 32'd0);
    end
    rstN = 1'b1;

    // R1: field positions, slot 0 (2^1) times slot 4 (3^2) = 18
    step(1'b1, FW'(2'd1), '0, 5'b00001, '0, FW'(2'd2) << (4*EXPW), 5'b10000, 18, "R1 slots 0x4");
    // R1: slot 2 (2^2*3^1=12) times slot 3 (2^0*3^3=27) = 324
    step(1'b1, FW'(2'd2) << (2*EXPW), FW'(2'd1) << (2*EXPW), 5'b00100,
         '0, FW'(2'd3) << (3*EXPW), 5'b01000, 324, "R1 slots 2x3");

    // R2/R6: back-to-back sweep over every 8-bit multiplicand
    for (int a = 0; a < 256; a++)
      for (int bi = 0; bi < 16; bi++)
        pairStep(a, (bi * 17 + a) % 256, "R2 sweep");

    // R6/R7: gapped inputs with garbage on idle cycles
    for (int n = 0; n < 40; n++) begin
      pairStep(int'($urandom % 256), int'($urandom % 256), "R6 gapped");
      idleStep();
      if (n % 3 == 0) idleStep();
    end

    // R3: no enabled terms on one side, garbage exponents
    step(1'b1, FW'($urandom), FW'($urandom), '0, FW'($urandom), FW'($urandom), '1, 0, "R3 A empty");
    step(1'b1, FW'($urandom), FW'($urandom), '1, FW'($urandom), FW'($urandom), '0, 0, "R3 B empty");
    step(1'b1, '1, '1, 5'b00010, '1, '1, 5'b00100, 46656, "R3 one pair among garbage");

    // R4: maximum single pairing
    step(1'b1, '1, '1, 5'b10000, '1, '1, 5'b00001, 46656, "R4 max pair");

    // R9: all terms maximal, wraps modulo 2^16
    step(1'b1, '1, '1, '1, '1, '1, '1, (5 * 216) * (5 * 216), "R9 wrap");

    // R5: a lone input after idles
    for (int n = 0; n < 8; n++) idleStep();
    pairStep(200, 131, "R5 lone");
    for (int n = 0; n < LAT + 4; n++) idleStep();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule